// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block sits on the bus side of a processor core. While the execution side is busy, it keeps a six-byte queue topped up with the instruction bytes that come next. It forms each 20-bit physical fetch address from a 16-bit code segment and a 16-bit instruction offset. The segment is shifted left by four bit positions and the offset is added to it. The fetch is word-wide on a request/acknowledge memory port. The execution side takes bytes one at a time from a valid/ready output, and fetching goes on in parallel with that consumption.

A new fetch is started only when the queue has room for at least two more bytes. If the fetch address is even, one word transfer brings in two bytes. If the address is odd, a single-byte transfer is issued first, which realigns the stream to an even address. When control flow is redirected, the execution side raises a flush with a new segment and offset. The queue is emptied at once. A response that was already on its way is thrown away, and fetching restarts from the new location.

Top module: `fetch_queue_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, `out_valid` and `mem_req` are low. The first request after reset is a word transfer (`mem_word`=1) at physical address 0xFFFF0, which is segment 0xFFFF with offset 0x0000.
- R2: The fetch address is (segment × 16 + offset) modulo 2^20. For example, segment 0xFFFF with offset 0x0010 gives address 0x00000.
- R3: An even fetch address is requested as a single word transfer (`mem_word`=1). Its `mem_rdata[7:0]` is queued as the byte at that address, followed by `mem_rdata[15:8]` as the next byte.
- R4: An odd fetch address is requested as a single-byte transfer (`mem_word`=0) that carries its byte in `mem_rdata[7:0]`. The offset then advances by one, so the following fetch is a word transfer at the next even address.
- R5: A request is raised only in a cycle after the queue held at most four bytes. The queue never holds more than six bytes. With the consumer stalled, exactly six bytes are loaded and then requests stop. Removing one byte (five held) starts no fetch. Removing a second byte (four held) starts one more word fetch.
- R6: Once raised, `mem_req` stays high with `mem_addr` and `mem_word` unchanged until the cycle in which `mem_ack` is high.
- R7: `out_data` shows the oldest queued byte whenever `out_valid` is high. A byte is removed only at a clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, `out_valid` and `out_data` hold.
- R8: A flush loads the new segment and offset and empties the queue at that clock edge, so `out_valid` is low in the cycle that follows. The next bytes delivered come from the new address.
- R9: If a request is outstanding when a flush arrives, the request completes on the bus but its data is discarded. The first request after it is at the flushed address.
- R10: The offset advances by the number of bytes loaded (1 or 2) and wraps modulo 2^16 within the segment. For example, offset 0xFFFF is followed by offset 0x0000 in the same segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Redirect: empty the queue and restart fetching at `flush_seg:flush_off` |
| flush_seg | input | 16 | New code segment, sampled when `flush` is high |
| flush_off | input | 16 | New instruction offset, sampled when `flush` is high |
| mem_req | output | 1 | Fetch request, held until acknowledged |
| mem_addr | output | 20 | Physical fetch address |
| mem_word | output | 1 | 1 = word transfer at even address, 0 = single byte at odd address |
| mem_ack | input | 1 | Memory completes the request in this cycle |
| mem_rdata | input | 16 | Fetched data, valid with `mem_ack`; byte transfers use bits 7:0 |
| out_valid | output | 1 | `out_data` holds a queued byte |
| out_data | output | 8 | Oldest queued instruction byte |
| out_ready | input | 1 | Execution side takes the byte at this edge when `out_valid` is high |

## Verification
A fetch request appears after the first clock edge at which the controller is idle and the registered occupancy shows at least two free slots. Fetched bytes become visible at the output after the edge that samples `mem_ack`. A flush takes effect at its own edge, so `out_valid` must be low in the very next cycle. A byte handshaken in a cycle leaves the head at the following edge. The bench drives and samples only on the falling clock edge, so each result is read one full register stage after the edge that produced it. Checks that depend on queue filling or memory latency wait a fixed margin well beyond the worst-case request–acknowledge–push chain. They then compare against a log of acknowledged transfers rather than against an exact cycle.

// File: rtl/fqu_pkg.sv
package fqu_pkg;
    parameter int SEG_W     = 16;
    parameter int OFF_W     = 16;
    parameter int PHYS_W    = 20;
    parameter int SEG_SHIFT = 4;
    parameter int QDEPTH    = 6;
    parameter int BYTE_W    = 8;

    typedef enum logic [1:0] {
        FETCH_IDLE = 2'd0,
        FETCH_BUSY = 2'd1,
        FETCH_DROP = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/fqu_addr_gen.sv
module fqu_addr_gen #(
    parameter int SEG_W     = fqu_pkg::SEG_W,
    parameter int OFF_W     = fqu_pkg::OFF_W,
    parameter int PHYS_W    = fqu_pkg::PHYS_W,
    parameter int SEG_SHIFT = fqu_pkg::SEG_SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [PHYS_W-1:0] phys
);
    logic [PHYS_W-1:0] base_w;
    logic [PHYS_W-1:0] off_w;

    generate
        if (SEG_SHIFT > 0) begin : g_shift
            assign base_w = PHYS_W'({seg, {SEG_SHIFT{1'b0}}});
        end else begin : g_noshift
            assign base_w = PHYS_W'(seg);
        end
    endgenerate

    assign off_w = PHYS_W'(off);
    // sum truncated to PHYS_W bits: wraps modulo 2^PHYS_W
    assign phys  = base_w + off_w;
endmodule

// File: rtl/fqu_byte_queue.sv
module fqu_byte_queue #(
    parameter int DEPTH  = fqu_pkg::QDEPTH,
    parameter int BYTE_W = fqu_pkg::BYTE_W,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [1:0]        push_n,
    input  logic [BYTE_W-1:0] push_lo,
    input  logic [BYTE_W-1:0] push_hi,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] slots;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } queue_t;

    queue_t q_q, q_d;

    logic [PTR_W-1:0] wr0_ptr, wr1_ptr, rd_next;
    logic [DEPTH-1:0] we_lo, we_hi;

    function automatic logic [PTR_W-1:0] ring(input int unsigned v);
        int unsigned r;
        r = (v >= DEPTH) ? v - DEPTH : v;
        return PTR_W'(r);
    endfunction

    assign wr0_ptr = ring(int'(q_q.rd) + int'(q_q.cnt));
    assign wr1_ptr = ring(int'(q_q.rd) + int'(q_q.cnt) + 1);
    assign rd_next = ring(int'(q_q.rd) + 1);

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            assign we_lo[s] = (push_n != 2'd0) && (wr0_ptr == PTR_W'(s));
            assign we_hi[s] = (push_n == 2'd2) && (wr1_ptr == PTR_W'(s));
        end
    endgenerate

    always_comb begin
        q_d = q_q;
        for (int s = 0; s < DEPTH; s++) begin
            if (we_lo[s]) q_d.slots[s] = push_lo;
            if (we_hi[s]) q_d.slots[s] = push_hi;
        end
        if (pop) q_d.rd = rd_next;
        q_d.cnt = q_q.cnt + CNT_W'(push_n) - CNT_W'(pop);
        if (clear) begin
            q_d.rd  = '0;
            q_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = q_q.slots[q_q.rd];
    assign count = q_q.cnt;
endmodule

// File: rtl/fqu_fetch_ctrl.sv
module fqu_fetch_ctrl
    import fqu_pkg::*;
#(
    parameter int              SEG_W     = fqu_pkg::SEG_W,
    parameter int              OFF_W     = fqu_pkg::OFF_W,
    parameter int              PHYS_W    = fqu_pkg::PHYS_W,
    parameter int              SEG_SHIFT = fqu_pkg::SEG_SHIFT,
    parameter int              DEPTH     = fqu_pkg::QDEPTH,
    parameter int              BYTE_W    = fqu_pkg::BYTE_W,
    parameter int              CNT_W     = $clog2(DEPTH + 1),
    parameter logic [SEG_W-1:0] RESET_SEG = '1,
    parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [SEG_W-1:0]    flush_seg,
    input  logic [OFF_W-1:0]    flush_off,
    input  logic [CNT_W-1:0]    q_count,
    input  logic                mem_ack,
    input  logic [2*BYTE_W-1:0] mem_rdata,
    output logic                mem_req,
    output logic [PHYS_W-1:0]   mem_addr,
    output logic                mem_word,
    output logic [1:0]          push_n,
    output logic [BYTE_W-1:0]   push_lo,
    output logic [BYTE_W-1:0]   push_hi
);
    typedef struct packed {
        fetch_state_e      state;
        logic [SEG_W-1:0]  seg;
        logic [OFF_W-1:0]  off;
        logic [PHYS_W-1:0] addr;
        logic              word;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        state: FETCH_IDLE,
        seg:   RESET_SEG,
        off:   RESET_OFF,
        addr:  '0,
        word:  1'b0
    };

    ctrl_t c_q, c_d;
    logic [PHYS_W-1:0] phys_now;
    logic              has_room;

    fqu_addr_gen #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .PHYS_W(PHYS_W), .SEG_SHIFT(SEG_SHIFT)
    ) u_addr (
        .seg  (c_q.seg),
        .off  (c_q.off),
        .phys (phys_now)
    );

    // room for a full word: at most DEPTH-2 bytes held
    assign has_room = (q_count <= CNT_W'(DEPTH - 2));

    always_comb begin
        c_d    = c_q;
        push_n = 2'd0;
        unique case (c_q.state)
            FETCH_IDLE: begin
                if (!flush && has_room) begin
                    c_d.state = FETCH_BUSY;
                    c_d.addr  = phys_now;
                    c_d.word  = ~phys_now[0];
                end
            end
            FETCH_BUSY: begin
                if (mem_ack) begin
                    c_d.state = FETCH_IDLE;
                    if (!flush) begin
                        push_n  = c_q.word ? 2'd2 : 2'd1;
                        c_d.off = c_q.off + OFF_W'(push_n);
                    end
                end else if (flush) begin
                    c_d.state = FETCH_DROP;
                end
            end
            FETCH_DROP: begin
                if (mem_ack) c_d.state = FETCH_IDLE;
            end
            default: c_d.state = FETCH_IDLE;
        endcase
        if (flush) begin
            c_d.seg = flush_seg;
            c_d.off = flush_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTRL_RESET;
        else        c_q <= c_d;
    end

    assign mem_req  = (c_q.state != FETCH_IDLE);
    assign mem_addr = c_q.addr;
    assign mem_word = c_q.word;
    assign push_lo  = mem_rdata[BYTE_W-1:0];
    assign push_hi  = mem_rdata[2*BYTE_W-1:BYTE_W];
endmodule

// File: rtl/fetch_queue_unit.sv
module fetch_queue_unit
    import fqu_pkg::*;
#(
    parameter int               SEG_W     = fqu_pkg::SEG_W,
    parameter int               OFF_W     = fqu_pkg::OFF_W,
    parameter int               PHYS_W    = fqu_pkg::PHYS_W,
    parameter int               SEG_SHIFT = fqu_pkg::SEG_SHIFT,
    parameter int               QDEPTH    = fqu_pkg::QDEPTH,
    parameter int               BYTE_W    = fqu_pkg::BYTE_W,
    parameter logic [SEG_W-1:0] RESET_SEG = '1,
    parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [SEG_W-1:0]    flush_seg,
    input  logic [OFF_W-1:0]    flush_off,
    output logic                mem_req,
    output logic [PHYS_W-1:0]   mem_addr,
    output logic                mem_word,
    input  logic                mem_ack,
    input  logic [2*BYTE_W-1:0] mem_rdata,
    output logic                out_valid,
    output logic [BYTE_W-1:0]   out_data,
    input  logic                out_ready
);
    localparam int CNT_W = $clog2(QDEPTH + 1);
    localparam int PTR_W = $clog2(QDEPTH);

    logic [CNT_W-1:0]  q_count;
    logic [1:0]        push_n;
    logic [BYTE_W-1:0] push_lo, push_hi;
    logic              pop;

    fqu_fetch_ctrl #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .PHYS_W(PHYS_W), .SEG_SHIFT(SEG_SHIFT),
        .DEPTH(QDEPTH), .BYTE_W(BYTE_W), .CNT_W(CNT_W),
        .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .flush_seg (flush_seg),
        .flush_off (flush_off),
        .q_count   (q_count),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_word  (mem_word),
        .push_n    (push_n),
        .push_lo   (push_lo),
        .push_hi   (push_hi)
    );

    fqu_byte_queue #(
        .DEPTH(QDEPTH), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .PTR_W(PTR_W)
    ) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (flush),
        .push_n  (push_n),
        .push_lo (push_lo),
        .push_hi (push_hi),
        .pop     (pop),
        .head    (out_data),
        .count   (q_count)
    );

    assign out_valid = (q_count != '0);
    assign pop       = out_valid & out_ready;
endmodule

// File: rtl/fqu_checker.sv
module fqu_checker #(
    parameter int DEPTH  = 6,
    parameter int CNT_W  = 3,
    parameter int PHYS_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_word,
    input logic [PHYS_W-1:0] mem_addr,
    input logic              out_valid,
    input logic [CNT_W-1:0]  q_count
);
    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_word)));

    assert_odd_is_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_addr[0]) |-> !mem_word);

    assert_even_is_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_addr[0]) |-> mem_word);

    assert_issue_with_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ($past(q_count) <= CNT_W'(DEPTH - 2)));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);
endmodule

bind fetch_queue_unit fqu_checker #(
    .DEPTH(QDEPTH), .CNT_W(CNT_W), .PHYS_W(PHYS_W)
) u_fqu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_word  (mem_word),
    .mem_addr  (mem_addr),
    .out_valid (out_valid),
    .q_count   (q_count)
);

// File: tb/fetch_queue_unit_tb.sv
module fetch_queue_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [15:0] flush_seg = '0, flush_off = '0;
    logic        mem_req, mem_word;
    logic [19:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;

    int errors = 0, checks = 0;
    bit done = 0;
    int lat = 0, wcnt = 0;
    int ack_total = 0, bytes_loaded = 0, hold_viol = 0, size_viol = 0;
    logic [20:0] acklog [0:1023];
    logic p_req = 0, p_ack = 0, p_word = 0;
    logic [19:0] p_addr = '0;
    logic [15:0] exp_seg = 16'hFFFF, exp_off = 16'h0000;
    logic [15:0] lfsr = 16'hACE1;

    fetch_queue_unit u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(flush_seg),
        .flush_off(flush_off), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_word(mem_word), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always #10ns clk = ~clk;

    function automatic logic [7:0] memb(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[3:0]} ^ 8'hA5;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    // memory responder
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wcnt >= lat) begin
                    mem_ack   <= 1'b1;
                    wcnt      <= 0;
                    mem_rdata <= mem_word ? {memb(mem_addr + 20'd1), memb(mem_addr)}
                                          : {8'h00, memb(mem_addr)};
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    // bus monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (p_req && !p_ack && (!mem_req || mem_addr != p_addr || mem_word != p_word))
                hold_viol++;
            if (mem_req && (mem_addr[0] == mem_word)) size_viol++;
            if (mem_req && mem_ack) begin
                acklog[ack_total % 1024] = {mem_word, mem_addr};
                ack_total++;
                bytes_loaded += mem_word ? 2 : 1;
            end
        end
        p_req  = mem_req;
        p_ack  = mem_ack;
        p_addr = mem_addr;
        p_word = mem_word;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // take n bytes; mode 0: ready always high, mode 1: pseudo-random ready
    task automatic consume(input int n, input int mode, input string req);
        int got = 0;
        int cyc = 0;
        logic [7:0] e;
        while (got < n && cyc < 5000) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = (mode == 0) ? 1'b1 : lfsr[0];
            if (out_valid && out_ready) begin
                e = memb(phys(exp_seg, exp_off));
                check(out_data == e, req, "byte", out_data, e);
                exp_off = exp_off + 16'd1;
                got++;
            end
            cyc++;
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(got == n, req, "bytes taken", got, n);
    endtask

    task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
        @(negedge clk);
        out_ready = 1'b0;
        flush = 1'b1; flush_seg = s; flush_off = o;
        @(negedge clk);
        flush = 1'b0;
        exp_seg = s; exp_off = o;
        check(out_valid == 1'b0, "R8", "valid after flush", out_valid, 0);
    endtask

    function automatic int find_ack(input int from, input logic [19:0] a);
        for (int i = from; i < ack_total; i++)
            if (acklog[i % 1024][19:0] == a) return i;
        return -1;
    endfunction

    task automatic t_reset();
        int n = 0;
        wait_cycles(3);
        check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
        check(mem_req == 1'b0, "R1", "req in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
        while (!mem_req && n < 10) begin @(negedge clk); n++; end
        check(mem_addr == 20'hFFFF0, "R1", "first addr", mem_addr, 20'hFFFF0);
        check(mem_word == 1'b1, "R1", "first word", mem_word, 1);
    endtask

    task automatic t_fill_limit();
        wait_cycles(40);
        check(bytes_loaded == 6, "R5", "bytes at full", bytes_loaded, 6);
        check(mem_req == 1'b0, "R5", "req at full", mem_req, 0);
        // R7: head holds while ready is low
        check(out_valid == 1'b1, "R7", "valid held", out_valid, 1);
        check(out_data == memb(20'hFFFF0), "R7", "head held", out_data, memb(20'hFFFF0));
        consume(1, 0, "R7");
        wait_cycles(20);
        check(bytes_loaded == 6, "R5", "five held no fetch", bytes_loaded, 6);
        consume(1, 0, "R3");
        wait_cycles(20);
        check(bytes_loaded == 8, "R5", "four held fetch", bytes_loaded, 8);
        // crosses segment 0xFFFF offset 0x0010 -> physical 0x00000
        consume(40, 0, "R2");
    endtask

    task automatic t_odd();
        int base, i;
        lat = 1;
        base = ack_total;
        do_flush(16'h1234, 16'h0101);
        wait_cycles(30);
        i = find_ack(base, 20'h12441);
        check(i >= 0, "R4", "odd fetch seen", i, base);
        if (i >= 0) begin
            check(acklog[i % 1024][20] == 1'b0, "R4", "odd is byte", acklog[i % 1024][20], 0);
            check(acklog[(i + 1) % 1024] == {1'b1, 20'h12442}, "R4", "then even word",
                  acklog[(i + 1) % 1024], {1'b1, 20'h12442});
        end
        consume(30, 1, "R4");
    endtask

    task automatic t_offwrap();
        lat = 0;
        do_flush(16'h2000, 16'hFFFD);
        consume(8, 0, "R10");
        check(exp_off == 16'h0005, "R10", "offset wrapped", exp_off, 16'h0005);
    endtask

    task automatic t_inflight();
        int base, n, i;
        lat = 6;
        do_flush(16'h4000, 16'h0000);
        n = 0;
        while (!(mem_req && mem_addr == 20'h40000) && n < 200) begin @(negedge clk); n++; end
        base = ack_total;
        check(mem_req == 1'b1, "R9", "request pending", mem_req, 1);
        do_flush(16'h5000, 16'h0033);
        wait_cycles(60);
        check(acklog[base % 1024][19:0] == 20'h40000, "R9", "old response completed",
              acklog[base % 1024][19:0], 20'h40000);
        i = find_ack(base, 20'h50033);
        check(i == base + 1, "R9", "next request at new address", i, base + 1);
        consume(10, 1, "R9");
    endtask

    initial begin
        t_reset();
        t_fill_limit();
        t_odd();
        t_offwrap();
        t_inflight();
        check(hold_viol == 0, "R6", "request held until ack", hold_viol, 0);
        check(size_viol == 0, "R3", "transfer size vs parity", size_viol, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4ms;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule